// File: doc/BRIEF.md
# Line-Buffered Frame Input Controller

This block governs how a raster-scanned image is admitted into a line-based two-dimensional wavelet transform engine. The image width, the image height and the decomposition level count are programmed through a small register-style write port while the block is idle. A start-of-frame pulse then opens the frame. The block grants the upstream pixel source permission to send, and it issues a write strobe with a column and row address into the line buffers for each accepted pixel.

Input is admitted in bursts. A priming batch of lines is admitted first, and later batches are two lines each. When a batch is complete, the permit is withdrawn and the filter datapath is told that lines are available. The permit returns only after the datapath answers with a processing-done pulse. After the batch that holds the bottom line has been processed, a one-cycle frame-done pulse is issued and the block is ready for a new start.

A geometry that the wavelet levels cannot divide evenly is flagged and cannot be started.

Top module: `lb_frame_ctrl`

## Requirements
- R1: Configuration writes (select 0 = width, 1 = height, 2 = level count, 3 = no register) take effect one cycle after the write only while the block is idle. Writes made during a frame leave `width_o`, `height_o` and `levels_o` unchanged. After reset the configuration is the maximum width, the maximum height and one level.
- R2: `cfg_err_o` is high while the stored configuration is invalid. A configuration is invalid when the width or the height is zero, exceeds its maximum, or is not a multiple of 2^MAX_LVL, or when the level count is zero or exceeds MAX_LVL. A start pulse is ignored while `cfg_err_o` is high.
- R3: In idle, `pix_ready_o` is low. A frame opens only on a start pulse with a valid configuration, and `pix_ready_o` is high from the next cycle.
- R4: While `pix_ready_o` is high, every cycle with `pix_valid_i` high asserts `buf_we_o` in that same cycle. The column and row addresses advance in raster order, left to right and top to bottom, starting from column 0, row 0.
- R5: The first batch is min(PRIME_LINES, height) lines. In the cycle after the last pixel of a batch, `pix_ready_o` is low and `lines_rdy_o` is high.
- R6: While `lines_rdy_o` is high, no pixel is accepted: `buf_we_o` stays low whatever `pix_valid_i` does.
- R7: A `proc_done_i` pulse during processing with lines still outstanding opens a batch of min(BATCH_LINES, remaining lines). `pix_ready_o` is high and `lines_rdy_o` is low in the next cycle.
- R8: A `proc_done_i` pulse after the bottom line's batch makes `frame_done_o` high for exactly the next cycle and returns the block to idle.
- R9: A start pulse during a frame has no effect on batching or addressing.
- R10: `proc_done_i` outside the processing phase has no effect. It produces no `frame_done_o` and does not change the permit or the batch count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 width, 1 height, 2 levels |
| cfg_data_i | input | CFG_DW | Configuration write data |
| cfg_err_o | output | 1 | Stored configuration invalid |
| width_o | output | $clog2(MAX_W+1) | Programmed image width |
| height_o | output | $clog2(MAX_H+1) | Programmed image height |
| levels_o | output | $clog2(MAX_LVL+1) | Programmed decomposition level count |
| sof_i | input | 1 | Start-of-frame pulse |
| pix_valid_i | input | 1 | Source presents a pixel |
| pix_ready_o | output | 1 | Permit to send pixels |
| buf_we_o | output | 1 | Line-buffer write strobe for the accepted pixel |
| buf_col_o | output | $clog2(MAX_W) | Column of the accepted pixel |
| buf_row_o | output | $clog2(MAX_H) | Row of the accepted pixel |
| lines_rdy_o | output | 1 | Buffered batch handed to the filter datapath |
| proc_done_i | input | 1 | Datapath finished the handed-over batch |
| frame_done_o | output | 1 | One-cycle pulse at the end of the frame |

## Verification
The bench builds the block with a maximum of 32×32 pixels, two levels (dimensions in steps of 4), a priming batch of 5 lines and later batches of 2 lines. With these values, whole frames are short enough to run many of them. A height of 4 falls below the priming count and gives a single short batch. Heights such as 8 or 12 end on a one-line batch. Widths of 6 and 36 and level counts of 0 and 3 exercise each rejection path.

// File: rtl/lbfc_pkg.sv
package lbfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROC = 2'd2
  } lbfc_state_e;

  localparam logic [1:0] SEL_WIDTH  = 2'd0;
  localparam logic [1:0] SEL_HEIGHT = 2'd1;
  localparam logic [1:0] SEL_LEVELS = 2'd2;
endpackage

// File: rtl/lbfc_cfg.sv
module lbfc_cfg #(
  parameter int MAX_W   = 1024,
  parameter int MAX_H   = 1024,
  parameter int MAX_LVL = 5,
  parameter int CFG_DW  = 16,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int LW = $clog2(MAX_LVL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [CFG_DW-1:0] data_i,
  input  logic              idle_i,
  output logic [WW-1:0]     width_o,
  output logic [HW-1:0]     height_o,
  output logic [LW-1:0]     levels_o,
  output logic              ok_o
);
  import lbfc_pkg::*;

  logic [CFG_DW-1:0] width_q, height_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q  <= CFG_DW'(MAX_W);
      height_q <= CFG_DW'(MAX_H);
      lvl_q    <= CFG_DW'(1);
    end else if (we_i && idle_i) begin
      case (sel_i)
        SEL_WIDTH:  width_q  <= data_i;
        SEL_HEIGHT: height_q <= data_i;
        SEL_LEVELS: lvl_q    <= data_i;
        default: ;
      endcase
    end
  end

  // full stored value is checked, so out-of-range data cannot alias to a legal one
  logic w_ok, h_ok, l_ok;
  assign w_ok = (width_q != '0) && (width_q <= CFG_DW'(MAX_W)) &&
                (width_q[MAX_LVL-1:0] == '0);
  assign h_ok = (height_q != '0) && (height_q <= CFG_DW'(MAX_H)) &&
                (height_q[MAX_LVL-1:0] == '0);
  assign l_ok = (lvl_q != '0) && (lvl_q <= CFG_DW'(MAX_LVL));
  assign ok_o = w_ok && h_ok && l_ok;

  assign width_o  = width_q[WW-1:0];
  assign height_o = height_q[HW-1:0];
  assign levels_o = lvl_q[LW-1:0];

  // R1
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> ($stable(width_q) && $stable(height_q) && $stable(lvl_q)));
endmodule

// File: rtl/lbfc_seq.sv
module lbfc_seq #(
  parameter int MAX_W       = 1024,
  parameter int MAX_H       = 1024,
  parameter int PRIME_LINES = 5,
  parameter int BATCH_LINES = 2,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int CW = $clog2(MAX_W),
  localparam int RW = $clog2(MAX_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] width_i,
  input  logic [HW-1:0] height_i,
  input  logic          cfg_ok_i,
  input  logic          sof_i,
  input  logic          pix_valid_i,
  input  logic          proc_done_i,
  output logic          idle_o,
  output logic          pix_ready_o,
  output logic          buf_we_o,
  output logic [CW-1:0] buf_col_o,
  output logic [RW-1:0] buf_row_o,
  output logic          lines_rdy_o,
  output logic          frame_done_o
);
  import lbfc_pkg::*;

  localparam logic [HW-1:0] PRIME_C = HW'(PRIME_LINES);
  localparam logic [HW-1:0] BATCH_C = HW'(BATCH_LINES);

  lbfc_state_e   state_q;
  logic [CW-1:0] col_q;
  logic [HW-1:0] row_q, left_q;
  logic          done_q;

  logic [HW-1:0] remain, first_tgt, next_tgt;
  logic          line_end, accept;

  assign remain    = height_i - row_q;
  assign first_tgt = (height_i < PRIME_C) ? height_i : PRIME_C;
  assign next_tgt  = (remain < BATCH_C) ? remain : BATCH_C;
  assign line_end  = (WW'(col_q) + WW'(1)) == width_i;
  assign accept    = (state_q == ST_FILL) && pix_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (sof_i && cfg_ok_i) begin
          state_q <= ST_FILL;
          col_q   <= '0;
          row_q   <= '0;
          left_q  <= first_tgt;
        end
        ST_FILL: if (pix_valid_i) begin
          if (line_end) begin
            col_q  <= '0;
            row_q  <= row_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == HW'(1)) state_q <= ST_PROC;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_PROC: if (proc_done_i) begin
          if (row_q == height_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            left_q  <= next_tgt;
            state_q <= ST_FILL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o       = (state_q == ST_IDLE);
  assign pix_ready_o  = (state_q == ST_FILL);
  assign lines_rdy_o  = (state_q == ST_PROC);
  assign buf_we_o     = accept;
  assign buf_col_o    = col_q;
  assign buf_row_o    = row_q[RW-1:0];
  assign frame_done_o = done_q;

  // R3
  start_needs_sof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && $past(state_q == ST_IDLE)) |-> $past(sof_i && cfg_ok_i));
  // R5
  batch_end_on_pixel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lines_rdy_o) |-> $past(buf_we_o));
  // R7
  resume_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lines_rdy_o) |-> $past(proc_done_i));
  // R8
  done_after_proc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> ($past(proc_done_i) && idle_o));
endmodule

// File: rtl/lb_frame_ctrl.sv
module lb_frame_ctrl #(
  parameter int MAX_W       = 1024,
  parameter int MAX_H       = 1024,
  parameter int MAX_LVL     = 5,
  parameter int PRIME_LINES = 5,
  parameter int BATCH_LINES = 2,
  parameter int CFG_DW      = 16,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1),
  localparam int LW = $clog2(MAX_LVL + 1),
  localparam int CW = $clog2(MAX_W),
  localparam int RW = $clog2(MAX_H)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_DW-1:0] cfg_data_i,
  output logic              cfg_err_o,
  output logic [WW-1:0]     width_o,
  output logic [HW-1:0]     height_o,
  output logic [LW-1:0]     levels_o,
  input  logic              sof_i,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  output logic              buf_we_o,
  output logic [CW-1:0]     buf_col_o,
  output logic [RW-1:0]     buf_row_o,
  output logic              lines_rdy_o,
  input  logic              proc_done_i,
  output logic              frame_done_o
);
  logic idle, cfg_ok;

  lbfc_cfg #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .MAX_LVL(MAX_LVL), .CFG_DW(CFG_DW)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .idle_i(idle),
    .width_o(width_o), .height_o(height_o), .levels_o(levels_o),
    .ok_o(cfg_ok)
  );

  lbfc_seq #(
    .MAX_W(MAX_W), .MAX_H(MAX_H),
    .PRIME_LINES(PRIME_LINES), .BATCH_LINES(BATCH_LINES)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .width_i(width_o), .height_i(height_o), .cfg_ok_i(cfg_ok),
    .sof_i(sof_i), .pix_valid_i(pix_valid_i), .proc_done_i(proc_done_i),
    .idle_o(idle), .pix_ready_o(pix_ready_o), .buf_we_o(buf_we_o),
    .buf_col_o(buf_col_o), .buf_row_o(buf_row_o),
    .lines_rdy_o(lines_rdy_o), .frame_done_o(frame_done_o)
  );

  assign cfg_err_o = !cfg_ok;
endmodule

// File: tb/lb_frame_ctrl_tb.sv
`timescale 1ns/1ps
module lb_frame_ctrl_tb;
  localparam int MAX_W = 32, MAX_H = 32, MAX_LVL = 2, PRIME = 5, BATCH = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        sof = 1'b0, pix_valid = 1'b0, proc_done = 1'b0;
  logic        cfg_err, pix_ready, buf_we, lines_rdy, frame_done;
  logic [5:0]  width_o, height_o;
  logic [1:0]  levels_o;
  logic [4:0]  buf_col, buf_row;

  int n_vec = 0, n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lb_frame_ctrl #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .MAX_LVL(MAX_LVL),
    .PRIME_LINES(PRIME), .BATCH_LINES(BATCH), .CFG_DW(16)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .cfg_err_o(cfg_err), .width_o(width_o), .height_o(height_o), .levels_o(levels_o),
    .sof_i(sof), .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
    .buf_we_o(buf_we), .buf_col_o(buf_col), .buf_row_o(buf_row),
    .lines_rdy_o(lines_rdy), .proc_done_i(proc_done), .frame_done_o(frame_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic bit cfg_valid(input int w, input int h, input int l);
    return (w > 0) && (w <= MAX_W) && (w % (1 << MAX_LVL) == 0) &&
           (h > 0) && (h <= MAX_H) && (h % (1 << MAX_LVL) == 0) &&
           (l > 0) && (l <= MAX_LVL);
  endfunction

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic run_frame(input int w, input int h, input int l);
    int row = 0;
    bit first = 1'b1;
    cfg_write(0, w); cfg_write(1, h); cfg_write(2, l);
    chk("R2 valid cfg", int'(cfg_err), cfg_valid(w, h, l) ? 0 : 1);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0; #1;
    chk("R3 ready after sof", int'(pix_ready), 1);
    while (row < h) begin
      int tgt = first ? imin(PRIME, h) : imin(BATCH, h - row);
      for (int ln = 0; ln < tgt; ln++) begin
        for (int c = 0; c < w; c++) begin
          repeat ($urandom % 3) begin
            pix_valid = 1'b0;
            proc_done = ($urandom % 4 == 0);  // stray done during fill: R10
            #1;
            chk("R10 ready held in fill", int'(pix_ready), 1);
            chk("R4 no strobe without valid", int'(buf_we), 0);
            @(negedge clk);
          end
          proc_done = 1'b0;
          pix_valid = 1'b1;
          #1;
          chk("R4 strobe", int'(buf_we), 1);
          chk("R4 col", int'(buf_col), c);
          chk("R4 row", int'(buf_row), row);
          @(negedge clk);
        end
        row++;
      end
      // valid kept high: must not be accepted
      sof = 1'b1;                 // R9
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_data = 16'(w == 4 ? 8 : 4);  // R1
      #1;
      chk("R5 ready low after batch", int'(pix_ready), 0);
      chk("R5 lines_rdy", int'(lines_rdy), 1);
      chk("R6 no strobe in proc", int'(buf_we), 0);
      @(negedge clk);
      sof = 1'b0; cfg_we = 1'b0;
      repeat ($urandom % 6) begin
        #1;
        chk("R6 no strobe in proc", int'(buf_we), 0);
        chk("R6 ready low in proc", int'(pix_ready), 0);
        chk("R1 width frozen", int'(width_o), w);
        @(negedge clk);
      end
      proc_done = 1'b1;
      @(negedge clk);
      proc_done = 1'b0; pix_valid = 1'b0;
      #1;
      if (row < h) begin
        chk("R7 ready after done", int'(pix_ready), 1);
        chk("R7 lines_rdy low", int'(lines_rdy), 0);
        chk("R7 no frame_done", int'(frame_done), 0);
      end else begin
        chk("R8 frame_done pulse", int'(frame_done), 1);
        chk("R8 ready low", int'(pix_ready), 0);
        @(negedge clk); #1;
        chk("R8 pulse one cycle", int'(frame_done), 0);
        chk("R1 width after frame", int'(width_o), w);
      end
      first = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R3 ready low at reset", int'(pix_ready), 0);
    chk("R5 lines_rdy low at reset", int'(lines_rdy), 0);
    chk("R8 frame_done low at reset", int'(frame_done), 0);
    chk("R1 reset width", int'(width_o), MAX_W);
    chk("R1 reset height", int'(height_o), MAX_H);
    chk("R1 reset levels", int'(levels_o), 1);
    chk("R2 reset cfg ok", int'(cfg_err), 0);

    // R10: done pulse in idle
    @(negedge clk); proc_done = 1'b1;
    @(negedge clk); proc_done = 1'b0; #1;
    chk("R10 no frame_done in idle", int'(frame_done), 0);
    chk("R10 ready stays low", int'(pix_ready), 0);

    // R2: rejections
    cfg_write(0, 6);  chk("R2 width not multiple", int'(cfg_err), 1);
    @(negedge clk); sof = 1'b1; @(negedge clk); sof = 1'b0; #1;
    chk("R2 sof rejected", int'(pix_ready), 0);
    cfg_write(0, 36); chk("R2 width too big", int'(cfg_err), 1);
    cfg_write(0, 0);  chk("R2 width zero", int'(cfg_err), 1);
    cfg_write(0, 8);  chk("R2 width ok", int'(cfg_err), 0);
    cfg_write(1, 2);  chk("R2 height not multiple", int'(cfg_err), 1);
    cfg_write(1, 8);  chk("R2 height ok", int'(cfg_err), 0);
    cfg_write(2, 3);  chk("R2 levels too big", int'(cfg_err), 1);
    cfg_write(2, 0);  chk("R2 levels zero", int'(cfg_err), 1);
    cfg_write(3, 5);  chk("R1 select 3 no effect", int'(cfg_err), 1);
    cfg_write(2, 2);  chk("R2 levels ok", int'(cfg_err), 0);

    // directed corners
    run_frame(4, 4, 1);    // below priming count
    run_frame(32, 8, 2);   // 5 + 2 + 1
    run_frame(4, 32, 2);   // tall
    run_frame(8, 12, 1);

    for (int i = 0; i < 8; i++)
      run_frame(4 * (1 + $urandom % 8), 4 * (1 + $urandom % 8), 1 + $urandom % 2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule